// File: doc/BRIEF.md
# Load-Use Stall Controller

This block lives in the decode stage of a five-stage in-order pipeline. Each cycle it looks at the instruction sitting in the execute stage. If that instruction reads data memory and its destination register is one of the two source registers named by the instruction now in decode, the loaded value will not exist in time, even with forwarding. The block then holds the program counter and the fetch/decode register for one cycle. In the same cycle it loads an all-zero control word into the decode/execute register, so a no-op bubble enters execute.

The decode/execute control word and its destination register number are modelled inside the block and brought out as outputs. The bubble it inserts therefore feeds straight back into the next detection. Because of that feedback, each load-use pair costs exactly one cycle. Forwarding, branch handling and the datapath belong to other blocks.

Top module: `lu_stall_ctrl`

## Requirements
- R1: `stall` is 1 when bit 2 of `idex_ctrl` (the memory-read flag) is 1 and `idex_rt` equals `dec_rs`, `dec_rt` or both; register 0 is compared like any other register.
- R2: `stall` is 0 when bit 2 of `idex_ctrl` is 0, whatever the register numbers. It is also 0 when that bit is 1 but `idex_rt` matches neither decode source.
- R3: While `stall` is 1, `pc_wr_en` and `fetch_wr_en` are 0; otherwise both are 1.
- R4: At a clock edge where `stall` is 1, `idex_ctrl` becomes all zeros: the execute-group bits [8:5], the memory-group bits [4:2] and the write-back-group bits [1:0].
- R5: At a clock edge where `stall` is 0, `idex_ctrl` takes the value of `dec_ctrl` and `idex_rt` takes the value of `dec_dest`, unchanged.
- R6: A stall lasts exactly one cycle. If the decode inputs are held, `stall` is 0 in the next cycle, and at the edge after that the held instruction enters with its real control word.
- R7: While `rst` (synchronous, active high) is sampled 1 at a clock edge, `idex_ctrl` and `idex_rt` become 0. As a result `stall` is 0 after reset.
- R8: At a stall edge the decode/execute register still updates with the bubble; the load that was in execute is not held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_ctrl | input | 9 | Control word produced by decode for the instruction in decode |
| dec_rs | input | 5 | First source register of the instruction in decode |
| dec_rt | input | 5 | Second source register of the instruction in decode |
| dec_dest | input | 5 | Register number decode passes on as the execute-stage target |
| pc_wr_en | output | 1 | Program counter write enable |
| fetch_wr_en | output | 1 | Fetch/decode pipeline register write enable |
| stall | output | 1 | Load-use hazard detected this cycle |
| idex_ctrl | output | 9 | Decode/execute control word (modelled register) |
| idex_rt | output | 5 | Decode/execute target register number (modelled register) |

## Verification
The hardest case to produce is a hazard whose execute-stage load was itself the instruction held by an earlier stall. To get there, one load must be stalled behind another load and must then become the producer for a second dependent instruction. The stimulus first clears the register with a non-load word, then loads a chosen producer and applies the source numbers. It then chains two dependent loads back to back, so that the second stall comes straight after the released first one. A reset applied while a load is waiting in execute covers the remaining corner case.

// File: rtl/lu_stall_pkg.sv
package lu_stall_pkg;

    localparam int REG_W   = 5;
    localparam int NUM_SRC = 2;

    typedef struct packed {
        logic       reg_dst;
        logic [1:0] alu_op;
        logic       alu_src;
    } ex_ctrl_t;

    typedef struct packed {
        logic branch;
        logic mem_wr;
        logic mem_rd;
    } mem_ctrl_t;

    typedef struct packed {
        logic mem_to_reg;
        logic reg_wr;
    } wb_ctrl_t;

    typedef struct packed {
        ex_ctrl_t  ex;
        mem_ctrl_t mem;
        wb_ctrl_t  wb;
    } stage_ctrl_t;

    localparam int CTRL_W = $bits(stage_ctrl_t);

    function automatic stage_ctrl_t bubble_word();
        stage_ctrl_t b;
        b = '0;
        return b;
    endfunction

    function automatic logic same_reg(input logic [REG_W-1:0] a,
                                      input logic [REG_W-1:0] b);
        return (a == b);
    endfunction

endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect
    import lu_stall_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int NS = NUM_SRC
) (
    input  logic          ex_is_load,
    input  logic [RW-1:0] ex_target,
    input  logic [RW-1:0] dec_src [NS],
    output logic          hazard
);

    logic [NS-1:0] hit;

    for (genvar i = 0; i < NS; i++) begin : g_src
        assign hit[i] = (ex_target == dec_src[i]);
    end

    assign hazard = ex_is_load & (|hit);

endmodule

// File: rtl/lu_ctrl_mux.sv
module lu_ctrl_mux
    import lu_stall_pkg::*;
(
    input  logic        insert_bubble,
    input  stage_ctrl_t ctrl_in,
    output stage_ctrl_t ctrl_out
);

    always_comb begin
        if (insert_bubble) begin
            ctrl_out = bubble_word();
        end else begin
            ctrl_out = ctrl_in;
        end
    end

endmodule

// File: rtl/lu_idex_reg.sv
module lu_idex_reg
    import lu_stall_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  stage_ctrl_t   d_ctrl,
    input  logic [RW-1:0] d_target,
    output stage_ctrl_t   q_ctrl,
    output logic [RW-1:0] q_target
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_ctrl   <= '0;
            q_target <= '0;
        end else begin
            q_ctrl   <= d_ctrl;
            q_target <= d_target;
        end
    end

endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl
    import lu_stall_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] dec_ctrl,
    input  logic [REG_W-1:0]  dec_rs,
    input  logic [REG_W-1:0]  dec_rt,
    input  logic [REG_W-1:0]  dec_dest,
    output logic              pc_wr_en,
    output logic              fetch_wr_en,
    output logic              stall,
    output logic [CTRL_W-1:0] idex_ctrl,
    output logic [REG_W-1:0]  idex_rt
);

    stage_ctrl_t            dec_word;
    stage_ctrl_t            next_word;
    stage_ctrl_t            ex_word;
    logic [REG_W-1:0]       ex_target;
    logic [REG_W-1:0]       src_list [NUM_SRC];

    assign dec_word    = stage_ctrl_t'(dec_ctrl);
    assign src_list[0] = dec_rs;
    assign src_list[1] = dec_rt;

    lu_hazard_detect #(.RW(REG_W), .NS(NUM_SRC)) u_detect (
        .ex_is_load (ex_word.mem.mem_rd),
        .ex_target  (ex_target),
        .dec_src    (src_list),
        .hazard     (stall)
    );

    lu_ctrl_mux u_mux (
        .insert_bubble (stall),
        .ctrl_in       (dec_word),
        .ctrl_out      (next_word)
    );

    lu_idex_reg #(.RW(REG_W)) u_idex (
        .clk      (clk),
        .rst      (rst),
        .d_ctrl   (next_word),
        .d_target (dec_dest),
        .q_ctrl   (ex_word),
        .q_target (ex_target)
    );

    assign pc_wr_en    = ~stall;
    assign fetch_wr_en = ~stall;
    assign idex_ctrl   = CTRL_W'(ex_word);
    assign idex_rt     = ex_target;

    // R2: no memory read in execute means no stall
    p_no_load_r2: assert property (@(posedge clk) disable iff (rst)
        !idex_ctrl[2] |-> !stall);

    // R4 / R8: a stall edge loads the bubble
    p_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        stall |=> (idex_ctrl == '0));

    // R5: pass-through when not stalling
    p_pass_r5: assert property (@(posedge clk) disable iff (rst)
        !stall |=> (idex_ctrl == $past(dec_ctrl)) && (idex_rt == $past(dec_dest)));

    // R6: never two stall cycles in a row
    p_single_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R7: reset clears the modelled register
    p_reset_r7: assert property (@(posedge clk)
        rst |=> (idex_ctrl == '0) && (idex_rt == '0));

    // R3: both front-end enables agree and oppose stall
    always_comb begin
        if (!rst) begin
            p_front_r3: assert ((pc_wr_en == fetch_wr_en) && (pc_wr_en != stall));
        end
    end

endmodule

// File: tb/test_lu_stall_ctrl.sv
module test_lu_stall_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] dec_ctrl = '0;
    logic [4:0] dec_rs = '0;
    logic [4:0] dec_rt = '0;
    logic [4:0] dec_dest = '0;
    logic       pc_wr_en, fetch_wr_en, stall;
    logic [8:0] idex_ctrl;
    logic [4:0] idex_rt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    lu_stall_ctrl i_lu_stall_ctrl (
        .clk(clk), .rst(rst), .dec_ctrl(dec_ctrl), .dec_rs(dec_rs),
        .dec_rt(dec_rt), .dec_dest(dec_dest), .pc_wr_en(pc_wr_en),
        .fetch_wr_en(fetch_wr_en), .stall(stall), .idex_ctrl(idex_ctrl),
        .idex_rt(idex_rt)
    );

    // ctrl word: bit2 = memory read, bit3 = memory write, bit0 = reg write
    localparam logic [8:0] LOAD_W  = 9'h007;
    localparam logic [8:0] ALU_W   = 9'h121;
    localparam logic [8:0] STORE_W = 9'h028;
    localparam logic [8:0] MARK_W  = 9'h1FB;

    // {producer ctrl, producer dest, rs, rt, expected stall}
    localparam int NV = 10;
    localparam logic [24:0] VEC [NV] = '{
        {LOAD_W,  5'd5,  5'd5,  5'd3,  1'b1},
        {LOAD_W,  5'd5,  5'd2,  5'd5,  1'b1},
        {LOAD_W,  5'd5,  5'd5,  5'd5,  1'b1},
        {LOAD_W,  5'd5,  5'd4,  5'd6,  1'b0},
        {ALU_W,   5'd5,  5'd5,  5'd5,  1'b0},
        {STORE_W, 5'd7,  5'd7,  5'd7,  1'b0},
        {LOAD_W,  5'd0,  5'd0,  5'd1,  1'b1},
        {LOAD_W,  5'd31, 5'd31, 5'd0,  1'b1},
        {LOAD_W,  5'd16, 5'd0,  5'd0,  1'b0},
        {LOAD_W,  5'd30, 5'd31, 5'd28, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        step();
        step();
        // R7: reset state
        check("R7 idex_ctrl", 32'(idex_ctrl), 32'h0);
        check("R7 idex_rt",   32'(idex_rt),   32'h0);
        check("R7 stall",     32'(stall),     32'h0);
        check("R3 pc_wr_en",  32'(pc_wr_en),  32'h1);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            logic [8:0] pc;
            logic [4:0] pd, prs, prt;
            logic       es;
            {pc, pd, prs, prt, es} = VEC[v];
            dec_ctrl = '0; dec_rs = 5'd9; dec_rt = 5'd9; dec_dest = 5'd9;
            step();
            dec_ctrl = pc; dec_dest = pd;
            step();
            check("R5 producer loaded", 32'(idex_ctrl), 32'(pc));
            dec_rs = prs; dec_rt = prt; dec_ctrl = MARK_W; dec_dest = 5'd12;
            #1;
            check(es ? "R1 stall" : "R2 no stall", 32'(stall), 32'(es));
            check("R3 pc_wr_en",    32'(pc_wr_en),    32'(!es));
            check("R3 fetch_wr_en", 32'(fetch_wr_en), 32'(!es));
            step();
            if (es) begin
                check("R4 bubble", 32'(idex_ctrl), 32'h0);
                check("R6 stall released", 32'(stall), 32'h0);
                step();
                check("R6 held instr enters", 32'(idex_ctrl), 32'(MARK_W));
                check("R6 held instr target", 32'(idex_rt), 32'd12);
            end else begin
                check("R5 pass ctrl", 32'(idex_ctrl), 32'(MARK_W));
                check("R5 pass rt",   32'(idex_rt),   32'd12);
            end
        end

        // R6/R8: chained dependent loads
        dec_ctrl = '0; step();
        dec_ctrl = LOAD_W; dec_dest = 5'd3; dec_rs = 5'd20; dec_rt = 5'd21;
        step();
        dec_ctrl = LOAD_W; dec_dest = 5'd4; dec_rs = 5'd3; dec_rt = 5'd22;
        #1;
        check("R1 first load-use", 32'(stall), 32'h1);
        step();
        check("R8 bubble after load", 32'(idex_ctrl), 32'h0);
        check("R6 no second stall", 32'(stall), 32'h0);
        step();
        check("R6 dependent load enters", 32'(idex_rt), 32'd4);
        dec_ctrl = ALU_W; dec_dest = 5'd8; dec_rs = 5'd11; dec_rt = 5'd4;
        #1;
        check("R1 chained stall", 32'(stall), 32'h1);
        step();
        check("R4 chained bubble", 32'(idex_ctrl), 32'h0);
        step();
        check("R5 alu enters", 32'(idex_ctrl), 32'(ALU_W));

        // R7: reset while a load waits in execute
        dec_ctrl = LOAD_W; dec_dest = 5'd6; dec_rs = 5'd0; dec_rt = 5'd0;
        step();
        dec_rs = 5'd6;
        rst = 1'b1;
        step();
        rst = 1'b0;
        #1;
        check("R7 mid-run ctrl", 32'(idex_ctrl), 32'h0);
        check("R7 mid-run stall", 32'(stall), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule